// File: doc/BRIEF.md
# Cartridge Program and Character Bank Mapper

This block translates addresses for a game cartridge that plugs into an 8-bit console. It holds a 64 KiB program ROM in four 16 KiB banks and a 64 KiB character RAM in sixteen 4 KiB banks. The CPU selects banks by writing one byte anywhere in the lower program window ($8000-$BFFF). The top two data bits pick the program bank seen in that window. The low four data bits pick the character bank seen in the upper pattern window ($1000-$1FFF). The upper program window ($C000-$FFFF) always shows the last program bank, and the lower pattern window ($0000-$0FFF) always shows logical character bank 0.

The character RAM's bank lines are driven inverted, so logical bank 0 reaches physical bank 15. The three low lines are also crossed over on their way to the RAM pins. Software cannot see either effect, because the RAM can only be reached through this block. The mapper never drives the data bus, so a register write takes the CPU's data as it is. Writes are taken on the falling edge of the CPU cycle strobe, which is sampled by the block's clock.

Top module: `cart_bank_mapper`

## Requirements
- R1: While reset is active the bank register is zero. After reset, CPU reads at $8000-$BFFF give program bank 0, and PPU accesses at $1000-$1FFF give logical character bank 0 (pins 4'b1111).
- R2: When the block sees a falling edge of cpu_strobe with cpu_rw low and cpu_addr_hi equal to 2'b10, the register loads at the next clock edge. cpu_data_hi (data bits 7:6) becomes the program bank, and cpu_data_lo (data bits 3:0) becomes the logical character bank.
- R3: A strobe falling edge leaves the register unchanged in three cases: cpu_addr_hi is 2'b11, cpu_addr_hi is below 2'b10, or cpu_rw is high.
- R4: The register changes only after a falling edge of cpu_strobe. A write request held while the strobe stays low, or while it rises, has no effect.
- R5: prg_rom_hi equals the program bank when cpu_addr_hi is 2'b10, and equals 2'b11 when cpu_addr_hi is 2'b11.
- R6: prg_ce_n is low only when cpu_addr_hi[1] is 1 and cpu_rw is high. The ROM is never enabled during a CPU write.
- R7: When ppu_addr_hi is 2'b01 the logical character bank is the register value. When ppu_addr_hi is 2'b00 it is 0.
- R8: chr_ram_hi is computed in two steps. First, p is the bitwise complement of the logical bank. The pins are then {p[3], p[0], p[1], p[2]}, from bit 3 down to bit 0. For example, logical 1 gives 4'b1011, logical 4 gives 4'b1110 and logical 12 gives 4'b0110.
- R9: chr_ce_n equals ppu_addr_hi[1], so the RAM is enabled below $2000. chr_we_n is low only when ppu_wr_n is low and ppu_addr_hi[1] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than cpu_strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_strobe | input | 1 | CPU cycle strobe; its falling edge takes a write |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| cpu_addr_hi | input | 2 | CPU address bits 15:14 |
| cpu_data_hi | input | 2 | CPU data bits 7:6 (program bank) |
| cpu_data_lo | input | 4 | CPU data bits 3:0 (character bank) |
| ppu_addr_hi | input | 2 | PPU address bits 13:12 |
| ppu_wr_n | input | 1 | PPU write strobe, active low |
| prg_rom_hi | output | 2 | Program ROM address bits 15:14 |
| prg_ce_n | output | 1 | Program ROM chip enable, active low |
| chr_ram_hi | output | 4 | Character RAM address bits 15:12, inverted and crossed over |
| chr_ce_n | output | 1 | Character RAM chip enable, active low |
| chr_we_n | output | 1 | Character RAM write enable, active low |

## Verification
A wrong register value shows up on prg_rom_hi as soon as the CPU reads the lower program window. It also shows up on chr_ram_hi as soon as the PPU reaches the upper pattern window. Both paths are combinational, so the fault is visible in the same cycle as the probe. A missed or spurious load becomes visible one clock after the strobe edge that caused it. The inversion and the crossed bit order are only visible as physical pin patterns, so the bench drives distinct logical banks and compares the exact pin codes. A fault on the fixed windows appears on any access to them, whatever the register holds.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int PRG_BANK_W = 2;
    localparam int CHR_BANK_W = 4;
    localparam int CPU_DEC_W  = 2;
    localparam int PPU_DEC_W  = 2;

    // CPU A15:A14 value that marks the register window
    localparam logic [CPU_DEC_W-1:0] REG_WINDOW = 2'b10;

    typedef struct packed {
        logic [PRG_BANK_W-1:0] prg;
        logic [CHR_BANK_W-1:0] chr;
    } bank_t;

    typedef struct packed {
        bank_t bank;
        logic  strobe_prev;
    } reg_state_t;
endpackage

// File: rtl/mapper_bank_reg.sv
module mapper_bank_reg
    import mapper_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_strobe,
    input  logic                  cpu_rw,
    input  logic [CPU_DEC_W-1:0]  cpu_addr_hi,
    input  logic [PRG_BANK_W-1:0] cpu_data_hi,
    input  logic [CHR_BANK_W-1:0] cpu_data_lo,
    output bank_t                 bank
);
    reg_state_t st_d, st_q;
    logic       strobe_fall;
    logic       load_hit;

    always_comb begin
        st_d             = st_q;
        st_d.strobe_prev = cpu_strobe;
        strobe_fall      = st_q.strobe_prev & ~cpu_strobe;
        load_hit         = strobe_fall & ~cpu_rw & (cpu_addr_hi == REG_WINDOW);
        if (load_hit) begin
            st_d.bank.prg = cpu_data_hi;
            st_d.bank.chr = cpu_data_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank = st_q.bank;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (st_q.bank == '0));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_fall && !cpu_rw && cpu_addr_hi == REG_WINDOW)
        |=> (st_q.bank == $past({cpu_data_hi, cpu_data_lo})));

    assert_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_fall && (cpu_rw || cpu_addr_hi != REG_WINDOW))
        |=> $stable(st_q.bank));

    assert_edge_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.strobe_prev && !cpu_strobe) |=> $stable(st_q.bank));
endmodule

// File: rtl/mapper_prg_map.sv
module mapper_prg_map
    import mapper_pkg::*;
(
    input  logic [CPU_DEC_W-1:0]  cpu_addr_hi,
    input  logic                  cpu_rw,
    input  logic [PRG_BANK_W-1:0] prg_sel,
    output logic [PRG_BANK_W-1:0] prg_rom_hi,
    output logic                  prg_ce_n
);
    localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;

    always_comb begin
        // A14 high selects the fixed upper window
        prg_rom_hi = cpu_addr_hi[0] ? LAST_BANK : prg_sel;
        // no bus conflict: ROM stays off the bus during writes
        prg_ce_n   = ~(cpu_addr_hi[CPU_DEC_W-1] & cpu_rw);
    end

    always_comb begin
        if (cpu_addr_hi == 2'b11)
            assert_fixed_last_R5: assert (prg_rom_hi == LAST_BANK);
        if (!cpu_rw)
            assert_rom_quiet_R6: assert (prg_ce_n);
    end
endmodule

// File: rtl/mapper_chr_map.sv
module mapper_chr_map
    import mapper_pkg::*;
(
    input  logic [PPU_DEC_W-1:0]  ppu_addr_hi,
    input  logic                  ppu_wr_n,
    input  logic [CHR_BANK_W-1:0] chr_sel,
    output logic [CHR_BANK_W-1:0] chr_ram_hi,
    output logic                  chr_ce_n,
    output logic                  chr_we_n
);
    localparam int TOP = CHR_BANK_W - 1;

    logic [CHR_BANK_W-1:0] logical_bank;
    logic [CHR_BANK_W-1:0] phys_bank;

    always_comb begin
        logical_bank = ppu_addr_hi[0] ? chr_sel : '0;
        phys_bank    = ~logical_bank;
        chr_ce_n     = ppu_addr_hi[PPU_DEC_W-1];
        chr_we_n     = ppu_wr_n | ppu_addr_hi[PPU_DEC_W-1];
    end

    // top line straight through, lower lines reversed onto the pins
    for (genvar k = 0; k < CHR_BANK_W; k++) begin : g_pin
        if (k == TOP) begin : g_top
            assign chr_ram_hi[k] = phys_bank[k];
        end else begin : g_low
            assign chr_ram_hi[k] = phys_bank[TOP-1-k];
        end
    end

    always_comb begin
        if (ppu_addr_hi == 2'b00)
            assert_fixed_window_R8: assert (chr_ram_hi == '1);
        if (ppu_addr_hi[PPU_DEC_W-1])
            assert_ram_off_R9: assert (chr_ce_n && chr_we_n);
    end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import mapper_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_strobe,
    input  logic                  cpu_rw,
    input  logic [CPU_DEC_W-1:0]  cpu_addr_hi,
    input  logic [PRG_BANK_W-1:0] cpu_data_hi,
    input  logic [CHR_BANK_W-1:0] cpu_data_lo,
    input  logic [PPU_DEC_W-1:0]  ppu_addr_hi,
    input  logic                  ppu_wr_n,
    output logic [PRG_BANK_W-1:0] prg_rom_hi,
    output logic                  prg_ce_n,
    output logic [CHR_BANK_W-1:0] chr_ram_hi,
    output logic                  chr_ce_n,
    output logic                  chr_we_n
);
    bank_t bank;

    mapper_bank_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_strobe  (cpu_strobe),
        .cpu_rw      (cpu_rw),
        .cpu_addr_hi (cpu_addr_hi),
        .cpu_data_hi (cpu_data_hi),
        .cpu_data_lo (cpu_data_lo),
        .bank        (bank)
    );

    mapper_prg_map u_prg (
        .cpu_addr_hi (cpu_addr_hi),
        .cpu_rw      (cpu_rw),
        .prg_sel     (bank.prg),
        .prg_rom_hi  (prg_rom_hi),
        .prg_ce_n    (prg_ce_n)
    );

    mapper_chr_map u_chr (
        .ppu_addr_hi (ppu_addr_hi),
        .ppu_wr_n    (ppu_wr_n),
        .chr_sel     (bank.chr),
        .chr_ram_hi  (chr_ram_hi),
        .chr_ce_n    (chr_ce_n),
        .chr_we_n    (chr_we_n)
    );
endmodule

// File: tb/sim_cart_bank_mapper.sv
module sim_cart_bank_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_strobe = 1'b1;
    logic       cpu_rw = 1'b1;
    logic [1:0] cpu_addr_hi = 2'b00;
    logic [1:0] cpu_data_hi = 2'b00;
    logic [3:0] cpu_data_lo = 4'h0;
    logic [1:0] ppu_addr_hi = 2'b00;
    logic       ppu_wr_n = 1'b1;
    logic [1:0] prg_rom_hi;
    logic       prg_ce_n;
    logic [3:0] chr_ram_hi;
    logic       chr_ce_n;
    logic       chr_we_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_bank_mapper u0 (.*);

    // {write A15:A14, write data, probe cpu A15:A14, probe ppu A13:A12, exp prg, exp chr pins}
    localparam logic [19:0] VEC [NVEC] = '{
        {2'b10, 8'h00, 2'b10, 2'b01, 2'd0, 4'b1111},
        {2'b10, 8'h41, 2'b10, 2'b01, 2'd1, 4'b1011},
        {2'b10, 8'h85, 2'b10, 2'b01, 2'd2, 4'b1010},
        {2'b10, 8'hFC, 2'b10, 2'b01, 2'd3, 4'b0110},
        {2'b10, 8'h0F, 2'b11, 2'b00, 2'd3, 4'b1111},
        {2'b10, 8'h32, 2'b10, 2'b01, 2'd0, 4'b1101},
        {2'b10, 8'h74, 2'b11, 2'b00, 2'd3, 4'b1111},
        {2'b10, 8'hB8, 2'b10, 2'b01, 2'd2, 4'b0111}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one CPU bus cycle with a falling strobe edge
    task automatic cpu_cycle(input logic [1:0] a, input logic [7:0] d, input logic rw);
        @(negedge clk);
        cpu_addr_hi = a; cpu_data_hi = d[7:6]; cpu_data_lo = d[3:0];
        cpu_rw = rw; cpu_strobe = 1'b1;
        @(negedge clk);
        cpu_strobe = 1'b0;
        @(negedge clk);
        cpu_strobe = 1'b1; cpu_rw = 1'b1;
    endtask

    task automatic probe(input logic [1:0] ca, input logic [1:0] pa);
        cpu_addr_hi = ca; cpu_rw = 1'b1; ppu_addr_hi = pa; ppu_wr_n = 1'b1;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        probe(2'b10, 2'b01);
        check("R1 prg", {6'd0, prg_rom_hi}, 8'd0);
        check("R1 chr", {4'd0, chr_ram_hi}, 8'h0F);
        rst_n = 1'b1;
        @(negedge clk);
        probe(2'b10, 2'b01);
        check("R1 prg after release", {6'd0, prg_rom_hi}, 8'd0);

        for (int i = 0; i < NVEC; i++) begin
            cpu_cycle(VEC[i][19:18], VEC[i][17:10], 1'b0);
            probe(VEC[i][9:8], VEC[i][7:6]);
            check("R2 R5 prg", {6'd0, prg_rom_hi}, {6'd0, VEC[i][5:4]});
            check("R7 R8 chr", {4'd0, chr_ram_hi}, {4'd0, VEC[i][3:0]});
        end

        // load a known value: prg 1, chr logical 1
        cpu_cycle(2'b10, 8'h41, 1'b0);
        // R3: writes outside the window or reads are ignored
        cpu_cycle(2'b11, 8'hFF, 1'b0);
        probe(2'b10, 2'b01);
        check("R3 upper window prg", {6'd0, prg_rom_hi}, 8'd1);
        check("R3 upper window chr", {4'd0, chr_ram_hi}, 8'h0B);
        cpu_cycle(2'b01, 8'hFF, 1'b0);
        probe(2'b10, 2'b01);
        check("R3 low addr prg", {6'd0, prg_rom_hi}, 8'd1);
        cpu_cycle(2'b10, 8'hFF, 1'b1);
        probe(2'b10, 2'b01);
        check("R3 read cycle chr", {4'd0, chr_ram_hi}, 8'h0B);

        // R4: strobe already low, then write request held, then rising edge
        @(negedge clk);
        cpu_strobe = 1'b0;
        @(negedge clk);
        cpu_addr_hi = 2'b10; cpu_data_hi = 2'b11; cpu_data_lo = 4'hF; cpu_rw = 1'b0;
        repeat (3) @(negedge clk);
        cpu_strobe = 1'b1;
        repeat (2) @(negedge clk);
        probe(2'b10, 2'b01);
        check("R4 prg", {6'd0, prg_rom_hi}, 8'd1);
        check("R4 chr", {4'd0, chr_ram_hi}, 8'h0B);

        // R5: fixed upper window
        probe(2'b11, 2'b01);
        check("R5 fixed", {6'd0, prg_rom_hi}, 8'd3);

        // R6: chip enable
        probe(2'b10, 2'b01);
        check("R6 read", {7'd0, prg_ce_n}, 8'd0);
        cpu_rw = 1'b0; #1;
        check("R6 write", {7'd0, prg_ce_n}, 8'd1);
        probe(2'b01, 2'b01);
        check("R6 low addr", {7'd0, prg_ce_n}, 8'd1);

        // R7: fixed lower pattern window ignores the register
        probe(2'b10, 2'b00);
        check("R7 fixed window", {4'd0, chr_ram_hi}, 8'h0F);

        // R9: RAM strobes
        ppu_addr_hi = 2'b01; ppu_wr_n = 1'b0; #1;
        check("R9 we low", {6'd0, chr_ce_n, chr_we_n}, 8'd0);
        ppu_addr_hi = 2'b10; #1;
        check("R9 above 2000", {6'd0, chr_ce_n, chr_we_n}, 8'd3);
        ppu_addr_hi = 2'b00; ppu_wr_n = 1'b1; #1;
        check("R9 read", {6'd0, chr_ce_n, chr_we_n}, 8'd1);

        // R1: reset in mid-run clears the register
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe(2'b10, 2'b01);
        check("R1 mid reset prg", {6'd0, prg_rom_hi}, 8'd0);
        check("R1 mid reset chr", {4'd0, chr_ram_hi}, 8'h0F);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule